// File: doc/BRIEF.md
# ATA PIO Register Cycle Sequencer

This block is the host side of a parallel ATA/ATAPI disk port for single register and programmed-I/O transfers. One request is one 16-bit access: the requester gives the register address, a one-hot block select, a read/write flag, write data and a transfer mode from 0 to 4, and pulses start. The sequencer presents the address and chip selects, waits out the address setup time, asserts the read or write strobe, holds it for the pulse width, and then recovers until the minimum cycle time of the selected mode has passed. The cycle ends with a one-clock done pulse and, on reads, the captured data word.

The attached device can stretch a cycle by pulling its ready line low. The sequencer looks at that line once, at a fixed delay after the strobe is asserted. If the line is low there, the strobe is held until the line returns high. If the device keeps the line low for longer than the permitted limit, the strobe is released anyway and the done pulse carries a timeout flag. Every time interval is a nanosecond figure turned into core clock counts by rounding up, with the clock period as a parameter.

Top module: `ata_pio_seq`

## Requirements
- R1: After start is sampled, the address and chip selects become valid on the next clock. The strobe follows S clocks later, where S = ceil(setup/CLK_NS), with setup 80 ns for modes 0 and 1 and 40 ns for modes 2, 3 and 4. `ata_cs_n` is the bitwise inverse of `req_cs`.
- R2: The strobe stays low for A = ceil(pulse/CLK_NS) clocks, with pulse 165, 125, 100, 80 and 70 ns for modes 0 to 4. The recovery time is R = max(1, C - S - A), where C = ceil(cycle/CLK_NS) and cycle is 600, 400, 360, 200 and 120 ns. Done is asserted S + A + R clocks after the address becomes valid, plus any wait clocks.
- R3: The ready input is sampled once, P = ceil(35/CLK_NS) clocks after the strobe is asserted. If it is high there, no wait is added, whatever it does before or after that point. If it is low there, the strobe is lengthened by W clocks, where W is the number of consecutive low samples starting at that point.
- R4: If the ready input is low for more than T = ceil(1250/CLK_NS) consecutive clocks from the sample point, the strobe is negated P + T clocks after its assertion. `rsp_timeout` is then high together with done, and read data is not updated.
- R5: A read captures `ata_dd_in` on the clock edge that negates the strobe, which is after the ready input has returned high. It holds that word on `rsp_rdata` until the next read completes. `ata_dd_oe` stays low throughout a read.
- R6: On a write, `ata_dd_out` carries the write data, and `ata_dd_oe` is high from the clock the address becomes valid until one clock after the write strobe is negated.
- R7: The address and chip selects stay valid for at least one clock after the strobe is negated. They return to idle (`ata_cs_n` = 2'b11) in the same clock as done.
- R8: `busy` is high from the clock after start until done. A start received while busy is ignored: there is no second cycle, no extra done, and the address does not change.
- R9: Mode values 5, 6 and 7 behave exactly like mode 4.
- R10: A read drives only `ata_rd_n` low and a write drives only `ata_wr_n` low. The two strobes are never low together.
- R11: In reset, both strobes are high, `ata_cs_n` = 2'b11, and `busy`, `rsp_done`, `rsp_timeout`, `ata_dd_oe` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, period CLK_NS |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Start pulse for one access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | One-hot register block select |
| req_addr | input | ADDR_W | Register address |
| req_mode | input | 3 | Transfer mode, 0..4 (above 4 treated as 4) |
| req_wdata | input | DATA_W | Write data |
| ata_iordy | input | 1 | Device ready, low stretches the cycle |
| ata_dd_in | input | DATA_W | Data bus as seen from the device |
| ata_dd_out | output | DATA_W | Data bus value driven on writes |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_addr | output | ADDR_W | Device register address |
| ata_cs_n | output | CS_W | Chip selects, active low |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| rsp_rdata | output | DATA_W | Last read word |
| rsp_done | output | 1 | One-clock pulse at the end of an access |
| rsp_timeout | output | 1 | With done: the ready limit was exceeded |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the block with CLK_NS = 5, which matches its own clock. At that period every interval spans many clocks: setup is 8 or 16 clocks, the pulse is 14 to 33 clocks, the sample point is 7 clocks and the ready limit is 250 clocks, so an off-by-one in any count shows up as a measured difference. This clock period keeps the sweep over all eight mode codes in both directions short. It also brings the exact ready-limit boundary within reach: exactly T low clocks still complete normally, and one more gives a timeout. The bench also places ready pulses just before, exactly at and just after the sample point.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int unsigned PIO_MODES        = 5;
  localparam int unsigned MODE_W           = 3;
  localparam int unsigned IORDY_SAMPLE_NS  = 35;
  localparam int unsigned IORDY_LIMIT_NS   = 1250;
  localparam int unsigned LONGEST_CYCLE_NS = 600;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_RECOV
  } pio_state_t;

  function automatic int unsigned ceil_div(int unsigned n, int unsigned d);
    return (n + d - 1) / d;
  endfunction

  // minimum complete cycle per mode
  function automatic int unsigned cycle_ns(int unsigned m);
    case (m)
      0:       return 600;
      1:       return 400;
      2:       return 360;
      3:       return 200;
      default: return 120;
    endcase
  endfunction

  // address valid before strobe
  function automatic int unsigned setup_ns(int unsigned m);
    return (m < 2) ? 80 : 40;
  endfunction

  // strobe active width
  function automatic int unsigned pulse_ns(int unsigned m);
    case (m)
      0:       return 165;
      1:       return 125;
      2:       return 100;
      3:       return 80;
      default: return 70;
    endcase
  endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned CW     = 5
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [CW-1:0]     setup_o,
  output logic [CW-1:0]     pulse_o,
  output logic [CW-1:0]     recov_o
);

  logic [CW-1:0] s_tab [PIO_MODES];
  logic [CW-1:0] a_tab [PIO_MODES];
  logic [CW-1:0] r_tab [PIO_MODES];

  for (genvar g = 0; g < PIO_MODES; g++) begin : g_mode
    localparam int unsigned S = ceil_div(setup_ns(g), CLK_NS);
    localparam int unsigned A = ceil_div(pulse_ns(g), CLK_NS);
    localparam int unsigned C = ceil_div(cycle_ns(g), CLK_NS);
    localparam int unsigned R = (C > S + A) ? (C - S - A) : 1;
    assign s_tab[g] = CW'(S);
    assign a_tab[g] = CW'(A);
    assign r_tab[g] = CW'(R);
  end

  logic [MODE_W-1:0] idx;
  assign idx = (mode_i > MODE_W'(PIO_MODES - 1)) ? MODE_W'(PIO_MODES - 1) : mode_i;

  always_comb begin
    setup_o = '0;
    pulse_o = '0;
    recov_o = '0;
    for (int m = 0; m < PIO_MODES; m++) begin
      if (idx == MODE_W'(m)) begin
        setup_o = s_tab[m];
        pulse_o = a_tab[m];
        recov_o = r_tab[m];
      end
    end
  end

endmodule

// File: rtl/ata_pio_wait.sv
module ata_pio_wait #(
  parameter int unsigned TW     = 8,
  parameter int unsigned LIMIT  = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic inc_i,
  output logic expired_o
);

  logic [TW-1:0] wc;

  always_ff @(posedge clk) begin
    if (rst)         wc <= '0;
    else if (load_i) wc <= TW'(1);
    else if (inc_i)  wc <= wc + 1'b1;
  end

  assign expired_o = (wc == TW'(LIMIT));

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_wr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_mode,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ata_iordy,
  input  logic [DATA_W-1:0] ata_dd_in,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  output logic [ADDR_W-1:0] ata_addr,
  output logic [CS_W-1:0]   ata_cs_n,
  output logic              ata_rd_n,
  output logic              ata_wr_n,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_timeout,
  output logic              busy
);

  localparam int unsigned CW  = $clog2(ceil_div(LONGEST_CYCLE_NS, CLK_NS) + 1);
  localparam int unsigned SMP = ceil_div(IORDY_SAMPLE_NS, CLK_NS);
  localparam int unsigned TO  = ceil_div(IORDY_LIMIT_NS, CLK_NS);
  localparam int unsigned EW  = $clog2(SMP + 1);
  localparam int unsigned TW  = $clog2(TO + 1);

  pio_state_t        state;
  logic [CW-1:0]     cnt;
  logic [EW-1:0]     el;
  logic [MODE_W-1:0] mode_q;
  logic              wr_q;
  logic              tmo_q;

  logic [MODE_W-1:0] sel_mode;
  logic [CW-1:0]     setup_cnt, pulse_cnt, recov_cnt;
  logic              sample_low, wait_inc, wait_expired;

  assign sel_mode = (state == ST_IDLE) ? req_mode : mode_q;

  ata_pio_timing #(.CLK_NS(CLK_NS), .CW(CW)) u_timing (
    .mode_i  (sel_mode),
    .setup_o (setup_cnt),
    .pulse_o (pulse_cnt),
    .recov_o (recov_cnt)
  );

  // single look at the ready line, a fixed delay into the strobe
  assign sample_low = (state == ST_STROBE) && (el == EW'(SMP - 1)) && !ata_iordy;
  assign wait_inc   = (state == ST_WAIT) && !ata_iordy && !wait_expired;

  ata_pio_wait #(.TW(TW), .LIMIT(TO)) u_wait (
    .clk       (clk),
    .rst       (rst),
    .load_i    (sample_low),
    .inc_i     (wait_inc),
    .expired_o (wait_expired)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      el          <= '0;
      mode_q      <= '0;
      wr_q        <= 1'b0;
      tmo_q       <= 1'b0;
      ata_dd_out  <= '0;
      ata_dd_oe   <= 1'b0;
      ata_addr    <= '0;
      ata_cs_n    <= '1;
      ata_rd_n    <= 1'b1;
      ata_wr_n    <= 1'b1;
      rsp_rdata   <= '0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_start) begin
            state      <= ST_SETUP;
            cnt        <= setup_cnt - 1'b1;
            mode_q     <= req_mode;
            wr_q       <= req_wr;
            ata_addr   <= req_addr;
            ata_cs_n   <= ~req_cs;
            ata_dd_out <= req_wdata;
            ata_dd_oe  <= req_wr;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= pulse_cnt - 1'b1;
            el    <= '0;
            if (wr_q) ata_wr_n <= 1'b0;
            else      ata_rd_n <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (el != EW'(SMP)) el <= el + 1'b1;
          if (sample_low) begin
            state <= ST_WAIT;
          end else if (cnt == '0) begin
            ata_rd_n <= 1'b1;
            ata_wr_n <= 1'b1;
            if (!wr_q) rsp_rdata <= ata_dd_in;
            state <= ST_RECOV;
            cnt   <= recov_cnt - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (ata_iordy) begin
            state <= ST_STROBE;
            cnt   <= cnt - 1'b1;
          end else if (wait_expired) begin
            ata_rd_n <= 1'b1;
            ata_wr_n <= 1'b1;
            tmo_q    <= 1'b1;
            state    <= ST_RECOV;
            cnt      <= recov_cnt - 1'b1;
          end
        end
        ST_RECOV: begin
          ata_dd_oe <= 1'b0;
          if (cnt == '0) begin
            state       <= ST_IDLE;
            ata_cs_n    <= '1;
            ata_addr    <= '0;
            rsp_done    <= 1'b1;
            rsp_timeout <= tmo_q;
            tmo_q       <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
  parameter int unsigned CS_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [CS_W-1:0] ata_cs_n,
  input logic            ata_rd_n,
  input logic            ata_wr_n,
  input logic            ata_dd_oe,
  input logic            rsp_done,
  input logic            rsp_timeout,
  input logic            busy
);

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(!ata_rd_n && !ata_wr_n));

  assert_select_in_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    (!ata_rd_n || !ata_wr_n) |-> (ata_cs_n != '1));

  assert_setup_before_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(ata_rd_n) || $fell(ata_wr_n)) |-> ($past(ata_cs_n) != '1));

  assert_hold_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(ata_rd_n) || $rose(ata_wr_n)) |-> (ata_cs_n != '1));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !busy);

  assert_timeout_with_done_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_timeout |-> rsp_done);

  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    !ata_rd_n |-> !ata_dd_oe);

endmodule

bind ata_pio_seq ata_pio_seq_chk #(.CS_W(CS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ata_cs_n    (ata_cs_n),
  .ata_rd_n    (ata_rd_n),
  .ata_wr_n    (ata_wr_n),
  .ata_dd_oe   (ata_dd_oe),
  .rsp_done    (rsp_done),
  .rsp_timeout (rsp_timeout),
  .busy        (busy)
);

// File: tb/sim_ata_pio_seq.sv
`timescale 1ns/1ps
module sim_ata_pio_seq;

  localparam int CLK_NS = 5;
  localparam int SMP = (35 + CLK_NS - 1) / CLK_NS;
  localparam int TO  = (1250 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0, req_wr = 1'b0;
  logic [1:0]  req_cs = 2'b00;
  logic [2:0]  req_addr = '0, req_mode = '0;
  logic [15:0] req_wdata = '0;
  logic        ata_iordy = 1'b1;
  logic [15:0] ata_dd_in = '0;
  logic [15:0] ata_dd_out, rsp_rdata;
  logic        ata_dd_oe, ata_rd_n, ata_wr_n, rsp_done, rsp_timeout, busy;
  logic [2:0]  ata_addr;
  logic [1:0]  ata_cs_n;

  int nchk = 0, nfail = 0;
  logic [15:0] last_rd = '0;

  always #2.5 clk = ~clk;

  ata_pio_seq #(.CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst(rst), .req_start(req_start), .req_wr(req_wr),
    .req_cs(req_cs), .req_addr(req_addr), .req_mode(req_mode),
    .req_wdata(req_wdata), .ata_iordy(ata_iordy), .ata_dd_in(ata_dd_in),
    .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_addr(ata_addr),
    .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
    .busy(busy)
  );

  function automatic int cdiv(int n); return (n + CLK_NS - 1) / CLK_NS; endfunction
  function automatic int t_cyc(int m);
    case (m) 0: return 600; 1: return 400; 2: return 360; 3: return 200; default: return 120; endcase
  endfunction
  function automatic int t_set(int m); return (m < 2) ? 80 : 40; endfunction
  function automatic int t_pul(int m);
    case (m) 0: return 165; 1: return 125; 2: return 100; 3: return 80; default: return 70; endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // lo/hi: ready line low for strobe-relative edges lo..hi (edge 1 = first after assertion)
  task automatic run_cycle(input int mode, input bit wr, input logic [1:0] cs,
                           input logic [2:0] adr, input logic [15:0] wd,
                           input logic [15:0] base, input int lo, input int hi,
                           input bit poke);
    int em, s, a, c, r, w, t, rr;
    int tcs, tlo, thi, tdone, oe_first, oe_last, ndone;
    bit exp_tmo, saw_rd, saw_wr, bad_data, busy_bad, tmo_seen, fin;
    logic [1:0]  cs_hi, cs_done;
    logic [2:0]  addr_hi;
    logic [15:0] rd_done, exp_rd;
    em = (mode > 4) ? 4 : mode;
    s = cdiv(t_set(em)); a = cdiv(t_pul(em)); c = cdiv(t_cyc(em));
    r = (c > s + a) ? c - s - a : 1;
    exp_tmo = 0; w = 0;
    if (lo <= SMP && hi >= SMP) begin
      if (hi - SMP + 1 > TO) begin exp_tmo = 1; w = SMP + TO - a; end
      else w = hi - SMP + 1;
    end
    exp_rd = exp_tmo ? last_rd : (base ^ 16'(a + w - 1));
    tcs = -1; tlo = -1; thi = -1; tdone = -1; oe_first = -1; oe_last = -1; ndone = 0;
    saw_rd = 0; saw_wr = 0; bad_data = 0; busy_bad = 0; tmo_seen = 0; fin = 0;
    cs_hi = '0; cs_done = '0; addr_hi = '0; rd_done = '0;
    @(negedge clk);
    req_mode = 3'(mode); req_wr = wr; req_cs = cs; req_addr = adr; req_wdata = wd;
    req_start = 1'b1; ata_dd_in = base; ata_iordy = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    t = 0;
    while (!fin) begin
      if (tcs < 0 && ata_cs_n != 2'b11) tcs = t;
      if (!ata_rd_n) saw_rd = 1;
      if (!ata_wr_n) saw_wr = 1;
      if (tlo < 0 && (!ata_rd_n || !ata_wr_n)) tlo = t;
      if (tlo >= 0 && thi < 0 && ata_rd_n && ata_wr_n) begin
        thi = t; cs_hi = ata_cs_n; addr_hi = ata_addr;
      end
      if (ata_dd_oe) begin
        if (oe_first < 0) oe_first = t;
        oe_last = t;
        if (ata_dd_out != wd) bad_data = 1;
      end
      if (rsp_done == busy) busy_bad = 1;
      if (rsp_done) begin
        ndone++; tdone = t; cs_done = ata_cs_n; rd_done = rsp_rdata; tmo_seen = rsp_timeout;
        fin = 1;
      end
      if (tlo >= 0 && thi < 0) begin
        rr = t - tlo;
        ata_iordy = !((rr + 1) >= lo && (rr + 1) <= hi);
        ata_dd_in = base ^ 16'(rr);
      end else begin
        ata_iordy = 1'b1;
        ata_dd_in = base;
      end
      if (poke && t == 3) begin req_start = 1'b1; req_addr = ~adr; end
      if (poke && t == 4) req_start = 1'b0;
      if (t > 2000) begin
        chk(0, "watchdog", t, 2000);
        fin = 1;
      end
      @(negedge clk);
      t++;
    end
    for (int k = 0; k < 3; k++) begin
      if (rsp_done) ndone++;
      @(negedge clk);
    end
    chk(tcs == 0 && tlo - tcs == s, "R1 setup", tlo - tcs, s);
    chk(thi - tlo == a + w, (lo <= hi) ? "R3 strobe length" : "R2 strobe length", thi - tlo, a + w);
    chk(tdone == s + a + w + r, (mode > 4) ? "R9 total length" : "R2 total length", tdone, s + a + w + r);
    chk(tmo_seen == exp_tmo, "R4 timeout flag", int'(tmo_seen), int'(exp_tmo));
    chk(wr ? (saw_wr && !saw_rd) : (saw_rd && !saw_wr), "R10 strobe select",
        int'({saw_rd, saw_wr}), wr ? 1 : 2);
    chk(cs_hi == ~cs && cs_done == 2'b11, "R7 select hold", int'({cs_hi, cs_done}), int'({~cs, 2'b11}));
    chk(ndone == 1 && !busy_bad, "R8 busy and single done", ndone, 1);
    if (poke) chk(addr_hi == adr, "R8 start ignored", int'(addr_hi), int'(adr));
    if (wr) begin
      chk(oe_first == 0 && oe_last == thi && !bad_data, "R6 write drive",
          oe_last, thi);
    end else begin
      chk(rd_done == exp_rd, "R5 read capture", int'(rd_done), int'(exp_rd));
      chk(oe_first < 0, "R5 bus released", oe_first, -1);
      last_rd = rd_done;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ata_rd_n && ata_wr_n && ata_cs_n == 2'b11 && !busy && !rsp_done &&
        !rsp_timeout && !ata_dd_oe && rsp_rdata == '0, "R11 reset state", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ata_rd_n && ata_wr_n && ata_cs_n == 2'b11 && !busy, "R11 after reset", int'(busy), 0);

    // all mode codes, both directions, ready line held high
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        run_cycle(m, d[0], m[0] ? 2'b10 : 2'b01, 3'(m), 16'hA500 + 16'(m),
                  16'h1200 + 16'(m * 16), 0, -1, 0);
      end
    end

    // ready line placement around the single sample point
    for (int i = 0; i < 3; i++) begin
      int m;
      m = i * 2;
      run_cycle(m, 0, 2'b01, 3'd1, 16'h0, 16'h3300, 1, SMP - 1, 0);        // glitch before: no wait
      run_cycle(m, 0, 2'b01, 3'd2, 16'h0, 16'h3400, SMP, SMP, 0);          // one low sample
      run_cycle(m, 0, 2'b10, 3'd3, 16'h0, 16'h3500, SMP + 1, SMP + 6, 0);  // after sample: ignored
      run_cycle(m, 0, 2'b01, 3'd4, 16'h0, 16'h3600, 3, SMP + 19, 0);       // 20-clock wait
      run_cycle(m, 1, 2'b10, 3'd5, 16'hC0DE, 16'h0, SMP, SMP + 9, 0);      // write stretched
    end

    // limit boundary: exactly TO low clocks completes, one more times out
    run_cycle(0, 0, 2'b01, 3'd6, 16'h0, 16'h4400, SMP, SMP + TO - 1, 0);
    run_cycle(0, 0, 2'b01, 3'd6, 16'h0, 16'h5500, 1, SMP + TO, 0);
    run_cycle(4, 1, 2'b10, 3'd7, 16'hBEEF, 16'h0, 1, SMP + TO + 4, 0);

    // start while busy
    run_cycle(1, 0, 2'b01, 3'd5, 16'h0, 16'h6600, 0, -1, 1);
    run_cycle(3, 1, 2'b10, 3'd2, 16'h1234, 16'h0, 0, -1, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule